// File: doc/BRIEF.md
# Four-Bank Pointer-Addressed Data Memory

This block is the working data store of a small signal-processing datapath. It holds four separate banks of 64 words, each word 32 bits wide. Every bank has its own 6-bit word pointer and its own data port. A port read or write always reaches the word that the bank's pointer names. After each port access the pointer steps forward by one, so a run of port accesses walks through a bank without any address arithmetic in the datapath. All four ports can be used in the same cycle.

A separate 8-bit combined address register gives indirect access to any single word in the memory. Its upper two bits name the bank and its lower six bits name the word. Indirect accesses leave every bank pointer and the combined register unchanged. Reads are synchronous. Read data and a one-cycle valid flag appear on the clock after the strobe.

Top module: `dram4`

## Requirements
- R1: After reset every bank pointer is 0, the combined address register is 0 (bank 0, word 0), and `rd_valid` and `ind_valid` are low.
- R2: A port write on bank b stores `port_wdata[32*b+31:32*b]` into the word at bank b's pointer.
- R3: A port read on bank b (with no port write on b) raises `rd_valid[b]` for exactly the next cycle. In that cycle `rd_data[32*b+31:32*b]` holds the word at the pointer as it stood at the strobe.
- R4: Each port access on a bank advances that bank's pointer by one, and the pointer wraps from 63 to 0.
- R5: A pointer write (`ptr_we[b]` with `ptr_wdata`) sets bank b's pointer for the next access. If a port access on b happens in the same cycle, that access uses the old pointer and the pointer takes the written value, not the incremented one.
- R6: A write to the combined register (`ra_we`) loads `ra_wdata`. Bits 7:6 select the bank and bits 5:0 select the word for indirect accesses. An indirect write stores `ind_wdata` there. An indirect read returns that word on `ind_rdata` with `ind_valid` high one cycle later. If `ind_rd` and `ind_wr` are both high, only the write happens.
- R7: Indirect accesses change neither any bank pointer nor the combined register.
- R8: Port accesses on different banks in the same cycle are carried out independently and do not affect one another.
- R9: An indirect access whose selected bank has a port access in the same cycle is dropped: nothing is written and `ind_valid` stays low.
- R10: If `port_rd[b]` and `port_wr[b]` are both high, only the write happens. `rd_valid[b]` stays low and the pointer advances once.
- R11: An indirect access in the same cycle as a combined-register write uses the address held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_we | input | 4 | Per-bank pointer load strobe |
| ptr_wdata | input | 6 | Pointer load value, shared by all banks |
| port_rd | input | 4 | Per-bank port read strobe |
| port_wr | input | 4 | Per-bank port write strobe |
| port_wdata | input | 128 | Port write data, bank b in bits 32*b+31:32*b |
| rd_valid | output | 4 | Per-bank read data valid, one cycle after the read strobe |
| rd_data | output | 128 | Port read data, bank b in bits 32*b+31:32*b |
| ra_we | input | 1 | Combined address register load strobe |
| ra_wdata | input | 8 | Combined address: bank in 7:6, word in 5:0 |
| ind_rd | input | 1 | Indirect read strobe |
| ind_wr | input | 1 | Indirect write strobe |
| ind_wdata | input | 32 | Indirect write data |
| ind_valid | output | 1 | Indirect read data valid |
| ind_rdata | output | 32 | Indirect read data |

## Verification
The bench first writes all four banks in lockstep from reset. It then reads them back through the combined register. This shows whether the pointers really started at zero and advanced on every access, and whether they wrapped at 63. Pointer reloads are placed in the same cycle as a port access, which separates the old-address-used, new-pointer-kept rule from the simpler load-then-access ordering. Indirect accesses are aimed at a bank that has port traffic in that cycle, and also sent in the same cycle as a combined-register write. These cases separate the drop rule and the old-address rule from their plausible alternatives. A long random mix of all strobes then confirms that banks do not interfere with one another.

// File: rtl/dram_pkg.sv
package dram_pkg;

    // Operation presented to one bank storage array in a cycle.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bank_op_e;

endpackage

// File: rtl/dram_ptr.sv
module dram_ptr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ld) begin
            ptr <= ld_val;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R5: a load wins over a same-cycle access
    p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> ptr == $past(ld_val));

    // R4: an access steps the pointer by one, modulo the depth
    p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld) |=> ptr == AW'($past(ptr) + 1));

    // R7: with no access and no load the pointer holds
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld) |=> $stable(ptr));

endmodule

// File: rtl/dram_bank.sv
module dram_bank
    import dram_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bank_op_e      op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        unique case (op)
            OP_WRITE: mem[addr] <= wdata;
            OP_READ:  rdata     <= mem[addr];
            default:  ;
        endcase
    end

    // R3: read data changes only after a read operation
    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_READ) |=> $stable(rdata));

endmodule

// File: rtl/dram_ra.sv
module dram_ra #(
    parameter int BW = 2,
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [BW+AW-1:0] d,
    output logic [BW-1:0]    bank,
    output logic [AW-1:0]    word
);

    logic [BW+AW-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    assign bank = q[BW+AW-1:AW];
    assign word = q[AW-1:0];

    // R6: the register loads the written address
    p_ra_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> {bank, word} == $past(d));

    // R7: without a write the combined address is kept
    p_ra_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable({bank, word}));

endmodule

// File: rtl/dram4.sv
module dram4
    import dram_pkg::*;
#(
    parameter  int NBANK = 4,
    parameter  int DW    = 32,
    parameter  int AW    = 6,
    localparam int BW    = $clog2(NBANK),
    localparam int RAW   = BW + AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NBANK-1:0]    ptr_we,
    input  logic [AW-1:0]       ptr_wdata,
    input  logic [NBANK-1:0]    port_rd,
    input  logic [NBANK-1:0]    port_wr,
    input  logic [NBANK*DW-1:0] port_wdata,
    output logic [NBANK-1:0]    rd_valid,
    output logic [NBANK*DW-1:0] rd_data,
    input  logic                ra_we,
    input  logic [RAW-1:0]      ra_wdata,
    input  logic                ind_rd,
    input  logic                ind_wr,
    input  logic [DW-1:0]       ind_wdata,
    output logic                ind_valid,
    output logic [DW-1:0]       ind_rdata
);

    logic [BW-1:0]    ra_bank;
    logic [AW-1:0]    ra_word;
    logic [NBANK-1:0] port_acc;
    logic             ind_req;
    logic             ind_go;
    logic [DW-1:0]    bank_rdata [NBANK];
    logic [BW-1:0]    ind_bank_q;

    assign port_acc = port_rd | port_wr;
    assign ind_req  = ind_rd | ind_wr;
    assign ind_go   = ind_req && !port_acc[ra_bank];

    dram_ra #(.BW(BW), .AW(AW)) u_ra (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ra_we),
        .d     (ra_wdata),
        .bank  (ra_bank),
        .word  (ra_word)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [AW-1:0] ptr;
        bank_op_e      op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic          ind_sel;

        assign ind_sel = ind_go && (ra_bank == BW'(b));

        dram_ptr #(.AW(AW)) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ptr_we[b]),
            .ld_val (ptr_wdata),
            .step   (port_acc[b]),
            .ptr    (ptr)
        );

        always_comb begin
            op   = OP_IDLE;
            addr = ptr;
            wd   = port_wdata[b*DW +: DW];
            if (port_wr[b]) begin
                op = OP_WRITE;
            end else if (port_rd[b]) begin
                op = OP_READ;
            end else if (ind_sel) begin
                addr = ra_word;
                wd   = ind_wdata;
                op   = ind_wr ? OP_WRITE : OP_READ;
            end
        end

        dram_bank #(.DW(DW), .AW(AW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .op    (op),
            .addr  (addr),
            .wdata (wd),
            .rdata (bank_rdata[b])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_valid[b] <= 1'b0;
            end else begin
                rd_valid[b] <= port_rd[b] && !port_wr[b];
            end
        end

        assign rd_data[b*DW +: DW] = bank_rdata[b];

        // R3: a lone port read yields valid on the next cycle
        p_port_rv_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (port_rd[b] && !port_wr[b]) |=> rd_valid[b]);

        // R10: a write on the port suppresses read valid
        p_wr_no_rv_r10: assert property (@(posedge clk) disable iff (!rst_n)
            port_wr[b] |=> !rd_valid[b]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_valid  <= 1'b0;
            ind_bank_q <= '0;
        end else begin
            ind_valid  <= ind_go && !ind_wr;
            ind_bank_q <= ra_bank;
        end
    end

    assign ind_rdata = bank_rdata[ind_bank_q];

    // R9: an indirect access colliding with port traffic is dropped
    p_ind_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req && port_acc[ra_bank]) |=> !ind_valid);

    // R6: an uncontested indirect read yields valid next cycle
    p_ind_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_rd && !ind_wr && !port_acc[ra_bank]) |=> ind_valid);

    // R1: no indirect valid without a read strobe the cycle before
    p_ind_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ind_rd |=> !ind_valid);

endmodule

// File: tb/tb_dram4.sv
`timescale 1ns/1ps
module tb_dram4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   ptr_we = '0;
    logic [5:0]   ptr_wdata = '0;
    logic [3:0]   port_rd = '0;
    logic [3:0]   port_wr = '0;
    logic [127:0] port_wdata = '0;
    logic [3:0]   rd_valid;
    logic [127:0] rd_data;
    logic         ra_we = 1'b0;
    logic [7:0]   ra_wdata = '0;
    logic         ind_rd = 1'b0;
    logic         ind_wr = 1'b0;
    logic [31:0]  ind_wdata = '0;
    logic         ind_valid;
    logic [31:0]  ind_rdata;

    always #4 clk = ~clk;

    dram4 dut (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .port_rd(port_rd), .port_wr(port_wr), .port_wdata(port_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ra_we(ra_we),
        .ra_wdata(ra_wdata), .ind_rd(ind_rd), .ind_wr(ind_wr),
        .ind_wdata(ind_wdata), .ind_valid(ind_valid), .ind_rdata(ind_rdata)
    );

    int unsigned checks = 0;
    int unsigned fails  = 0;

    // behavioural reference state
    logic [31:0] m_mem [4][64];
    int          m_ptr [4];
    int          m_ra;
    bit          e_pv [4];
    logic [31:0] e_pd [4];
    bit          e_iv;
    logic [31:0] e_id;

    task automatic chk(bit ok, string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic idle();
        ptr_we = '0; port_rd = '0; port_wr = '0; ra_we = 1'b0;
        ind_rd = 1'b0; ind_wr = 1'b0;
    endtask

    task automatic model_apply();
        bit acc [4];
        int rb, rw;
        rb = m_ra / 64;
        rw = m_ra % 64;
        for (int b = 0; b < 4; b++) begin
            acc[b] = port_rd[b] | port_wr[b];
            e_pv[b] = 1'b0;
            if (port_wr[b]) begin
                m_mem[b][m_ptr[b]] = port_wdata[b*32 +: 32];
            end else if (port_rd[b]) begin
                e_pv[b] = 1'b1;
                e_pd[b] = m_mem[b][m_ptr[b]];
            end
        end
        e_iv = 1'b0;
        if ((ind_rd || ind_wr) && !acc[rb]) begin
            if (ind_wr) begin
                m_mem[rb][rw] = ind_wdata;
            end else begin
                e_iv = 1'b1;
                e_id = m_mem[rb][rw];
            end
        end
        for (int b = 0; b < 4; b++) begin
            if (ptr_we[b]) m_ptr[b] = int'(ptr_wdata);
            else if (acc[b]) m_ptr[b] = (m_ptr[b] + 1) % 64;
        end
        if (ra_we) m_ra = int'(ra_wdata);
    endtask

    task automatic compare(string tag);
        for (int b = 0; b < 4; b++) begin
            chk(rd_valid[b] == e_pv[b], tag, $sformatf("rd_valid[%0d]", b),
                32'(rd_valid[b]), 32'(e_pv[b]));
            if (e_pv[b])
                chk(rd_data[b*32 +: 32] == e_pd[b], tag, $sformatf("rd_data[%0d]", b),
                    rd_data[b*32 +: 32], e_pd[b]);
        end
        chk(ind_valid == e_iv, tag, "ind_valid", 32'(ind_valid), 32'(e_iv));
        if (e_iv) chk(ind_rdata == e_id, tag, "ind_rdata", ind_rdata, e_id);
    endtask

    // called at a falling edge with inputs already set
    task automatic step(string tag);
        model_apply();
        @(negedge clk);
        compare(tag);
        idle();
    endtask

    task automatic ind_read_at(int addr, string tag);
        ra_we = 1'b1; ra_wdata = 8'(addr);
        step(tag);
        ind_rd = 1'b1;
        step(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        for (int b = 0; b < 4; b++) begin
            m_ptr[b] = 0; e_pv[b] = 1'b0; e_pd[b] = '0;
            for (int w = 0; w < 64; w++) m_mem[b][w] = '0;
        end
        m_ra = 0; e_iv = 1'b0; e_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset, no valid flags
        step("R1");

        // R2 R8: fill all banks in lockstep from pointer zero
        for (int i = 0; i < 64; i++) begin
            port_wr = 4'hF;
            for (int b = 0; b < 4; b++)
                port_wdata[b*32 +: 32] = {8'(b), 8'(i), 16'($urandom)};
            step("R2");
        end

        // R1: reset combined address points at bank 0 word 0
        ind_rd = 1'b1;
        step("R1");
        step("R1");

        // R3 R4: pointers wrapped back to 0, read words 0..2 on all banks
        for (int i = 0; i < 3; i++) begin
            port_rd = 4'hF;
            step("R3");
        end
        step("R3");

        // R4: reload bank 1 near the end, read across the wrap
        ptr_we = 4'b0010; ptr_wdata = 6'd62;
        step("R5");
        for (int i = 0; i < 3; i++) begin
            port_rd = 4'b0010;
            step("R4");
        end
        step("R4");

        // R5: load and read in the same cycle on bank 2
        ptr_we = 4'b0100; ptr_wdata = 6'd40; port_rd = 4'b0100;
        step("R5");
        port_rd = 4'b0100;
        step("R5");
        step("R5");

        // R6 R7: indirect write then read of bank 3 word 5
        ra_we = 1'b1; ra_wdata = 8'hC5;
        step("R6");
        ind_wr = 1'b1; ind_wdata = 32'hCAFE_0005;
        step("R6");
        ind_rd = 1'b1; ind_wr = 1'b1; ind_wdata = 32'hBEEF_0005;
        step("R6");
        ind_rd = 1'b1;
        step("R6");
        port_rd = 4'b1000;
        step("R7");
        step("R7");

        // R11: address written in the same cycle is not yet used
        ra_we = 1'b1; ra_wdata = 8'h47; ind_rd = 1'b1;
        step("R11");
        ind_rd = 1'b1;
        step("R11");
        step("R11");

        // R9: indirect write to bank 1 collides with a port read on bank 1
        ind_wr = 1'b1; ind_wdata = 32'hDEAD_0007; port_rd = 4'b0010;
        step("R9");
        ind_rd = 1'b1; port_wr = 4'b0010; port_wdata[63:32] = 32'h1111_2222;
        step("R9");
        ind_rd = 1'b1;
        step("R9");
        step("R9");

        // R10: read and write together on bank 0
        port_rd = 4'b0001; port_wr = 4'b0001; port_wdata[31:0] = 32'h5A5A_0101;
        step("R10");
        port_rd = 4'b0001;
        step("R10");
        step("R10");
        ind_read_at(8'h03, "R10");
        step("R10");

        // R8: random mix of all strobes
        for (int n = 0; n < 4000; n++) begin
            for (int b = 0; b < 4; b++) begin
                int r;
                r = int'($urandom % 8);
                port_rd[b] = (r == 1) || (r == 2) || (r == 7);
                port_wr[b] = (r == 3) || (r == 7);
                ptr_we[b]  = ($urandom % 16) == 0;
                port_wdata[b*32 +: 32] = $urandom;
            end
            ptr_wdata = 6'($urandom);
            ra_we     = ($urandom % 6) == 0;
            ra_wdata  = 8'($urandom);
            ind_rd    = ($urandom % 3) == 0;
            ind_wr    = ($urandom % 5) == 0;
            ind_wdata = $urandom;
            step("R8");
        end
        step("R8");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule